// File: doc/BRIEF.md
# MDIO Management Register Bridge

This block lets a host reach the management registers of an Ethernet PHY through two 32-bit registers on a simple register bus. For a write, the host first places the 16-bit value in the data register. It then writes the command register with the PHY address, the register index and the direction. That write sets the busy flag, and the bridge serialises one complete management frame on MDC/MDIO. When the frame ends, busy clears. For a read, the bits captured from the PHY are then in the low half of the data register.

MDC is produced from the system clock by a divider. Each MDC phase lasts `MDC_HALF` system cycles, and MDC idles low. The frame starts with `PREAMBLE_BITS` ones. Then come the start code, the opcode, the two 5-bit address fields, a turnaround and 16 data bits, all sent most-significant bit first. On a read, the bridge stops driving MDIO from the turnaround onward and samples the PHY on each rising edge of MDC.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset, both registers read 0, MDC is low and MDIO is not driven.
- R2: The command register (bus_addr = 0) reads back PHY address in bits 15:11, register index in bits 10:6, direction in bit 1 (1 = write to PHY, 0 = read) and busy in bit 0; all other bits read 0.
- R3: A command-register write while idle sets busy in the next cycle and starts the frame, with MDIO driven from that cycle.
- R4: While busy, MDC has a period of 2*MDC_HALF system cycles, low for the first MDC_HALF cycles of each bit; while idle, MDC is low.
- R5: A frame sends PREAMBLE_BITS ones, start 01, opcode 10 (read) or 01 (write), the 5-bit PHY address and the 5-bit register index, MSB first, one bit per MDC period, each bit changing only at a falling MDC edge.
- R6: A write frame follows the index with turnaround 10 and bits 15:0 of the data register as held at the start of the frame, MSB first, with MDIO driven for the whole frame.
- R7: A read frame releases MDIO (output enable low) for the turnaround and the 16 data bits, samples MDIO on each rising MDC edge of the data bits, and on completion writes the 16 captured bits, first bit as bit 15, into data register bits 15:0 with bits 31:16 cleared.
- R8: Busy stays set for exactly (PREAMBLE_BITS+32)*2*MDC_HALF cycles, and MDC and output enable return low when it clears.
- R9: A command-register write while busy is ignored: fields, busy and the running frame are unchanged.
- R10: The data register (bus_addr = 1) holds all 32 written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 command, 1 data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
If the bit counter or the divider state goes wrong, the edge placement or the output enable on MDC/MDIO differs from the reference within one MDC period. A slipped frame end shows at once as a busy bit that clears early or late in the command readback. The bench compares MDC, the output enable, the driven MDIO bit and the selected register's read value against a behavioural model on every clock. A capture error appears in the data readback on the first cycle after a read completes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W      = 5;
    localparam int WORD_W      = 16;
    localparam int CTL_BUSY    = 0;
    localparam int CTL_DIR     = 1;
    localparam int CTL_REG_LSB = 6;
    localparam int CTL_PHY_LSB = 11;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regi;
        logic              wr;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == CNT_W'(HALF - 1));
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = tick & ~st_q.mdc;
    assign fall_tick = tick & st_q.mdc;

    // R4: between ticks the clock level holds
    a_r4_mdc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise_tick && !fall_tick) |=> $stable(mdc));
    // R4: clock parks low once the run request drops
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        busy,
    input  logic        rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic        start,
    output mdio_cmd_t   cmd_new,
    output logic [WORD_W-1:0] wr_word
);
    typedef struct packed {
        mdio_cmd_t   cmd;
        logic [31:0] data;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        cmd_new.phy  = bus_wdata[CTL_PHY_LSB +: ADDR_W];
        cmd_new.regi = bus_wdata[CTL_REG_LSB +: ADDR_W];
        cmd_new.wr   = bus_wdata[CTL_DIR];
        start        = bus_we && !bus_addr && !busy;

        st_d = st_q;
        if (start) st_d.cmd = cmd_new;
        if (rd_valid)
            st_d.data = {16'h0000, rd_data};
        else if (bus_we && bus_addr)
            st_d.data = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) begin
            bus_rdata = st_q.data;
        end else begin
            bus_rdata[CTL_PHY_LSB +: ADDR_W] = st_q.cmd.phy;
            bus_rdata[CTL_REG_LSB +: ADDR_W] = st_q.cmd.regi;
            bus_rdata[CTL_DIR]               = st_q.cmd.wr;
            bus_rdata[CTL_BUSY]              = busy;
        end
    end

    assign wr_word = st_q.data[WORD_W-1:0];

    // R9: a command write during a frame leaves the command fields alone
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && !bus_addr) |=> $stable(st_q.cmd));
    // R7: the captured word lands with the upper half cleared
    a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (st_q.data[31:16] == 16'h0000));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  mdio_cmd_t  cmd,
    input  logic [WORD_W-1:0] wr_word,
    input  logic       rise_tick,
    input  logic       fall_tick,
    input  logic       mdio_i,
    output logic       busy,
    output logic       done,
    output logic       rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic       mdio_o,
    output logic       mdio_oe
);
    localparam int FRAME   = PREAMBLE_BITS + 32;
    localparam int IDX_W   = $clog2(FRAME);
    localparam int RELEASE = PREAMBLE_BITS + 14;
    localparam int CAPTURE = PREAMBLE_BITS + 16;

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [IDX_W-1:0]  bitn;
        logic [FRAME-1:0]  frame;
        logic [WORD_W-1:0] rsh;
    } shf_t;

    shf_t st_d, st_q;
    logic [1:0] op, ta;
    logic [WORD_W-1:0] payload;
    logic last;

    always_comb begin
        op      = cmd.wr ? 2'b01 : 2'b10;
        ta      = cmd.wr ? 2'b10 : 2'b00;
        payload = cmd.wr ? wr_word : '0;
        last    = (st_q.bitn == IDX_W'(FRAME - 1));
        done    = st_q.busy && fall_tick && last;

        st_d = st_q;
        if (start && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.wr    = cmd.wr;
            st_d.bitn  = '0;
            st_d.frame = {{PREAMBLE_BITS{1'b1}}, 2'b01, op, cmd.phy, cmd.regi, ta, payload};
            st_d.rsh   = '0;
        end else if (st_q.busy) begin
            if (rise_tick && !st_q.wr && (st_q.bitn >= IDX_W'(CAPTURE)))
                st_d.rsh = {st_q.rsh[WORD_W-2:0], mdio_i};
            if (fall_tick) begin
                if (last) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.frame = {st_q.frame[FRAME-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign rd_valid = done & ~st_q.wr;
    assign rd_data  = st_q.rsh;
    assign mdio_o   = st_q.busy & st_q.frame[FRAME-1];
    assign mdio_oe  = st_q.busy & (st_q.wr | (st_q.bitn < IDX_W'(RELEASE)));

    // R5: first preamble bit is a driven one
    a_r5_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o));
    // R5: the data line only moves at a falling clock tick
    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_tick) |=> $stable(mdio_o));
    // R3: a start request while idle raises busy
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
    import mdio_pkg::*;
#(
    parameter int MDC_HALF      = 4,
    parameter int PREAMBLE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int FRAME_CYC = (PREAMBLE_BITS + 32) * 2 * MDC_HALF;
    localparam int CHK_W     = $clog2(FRAME_CYC + 1);

    logic busy, done, rd_valid, start, rise_tick, fall_tick;
    logic [WORD_W-1:0] rd_data, wr_word;
    mdio_cmd_t cmd_new;

    mdio_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .start(start), .cmd_new(cmd_new), .wr_word(wr_word)
    );

    mdio_clkdiv #(.HALF(MDC_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_shifter #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_shf (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_new), .wr_word(wr_word),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // checker counter: cycles spent busy
    logic [CHK_W-1:0] chk_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chk_cnt_q <= '0;
        else if (!busy) chk_cnt_q <= '0;
        else            chk_cnt_q <= chk_cnt_q + 1'b1;
    end

    // R8: frame length in system cycles
    a_r8_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_cnt_q == CHK_W'(FRAME_CYC - 1)));
    // R4 R8: clock low whenever idle
    a_r4_mdc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R8: line released whenever idle
    a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/sim_mdio_reg_bridge.sv
module sim_mdio_reg_bridge;
    localparam int HALF = 4;
    localparam int PER  = 2 * HALF;
    localparam int FR   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    mdio_reg_bridge #(.MDC_HALF(HALF), .PREAMBLE_BITS(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int errors = 0;
    int checks = 0;
    bit running = 0;
    bit finished = 0;

    // reference model state
    bit          busy_m = 0;
    int          k = 0;
    logic [63:0] frame_m = '0;
    logic        dir_m = 0;
    logic [4:0]  phy_m = '0, reg_m = '0;
    logic [31:0] data_m = '0;
    logic [15:0] phy_val = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ctl_word(input logic [4:0] p, input logic [4:0] r, input logic w);
        return {16'h0000, p, r, 4'b0000, w, 1'b0};
    endfunction

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // model update at the active edge
    always @(posedge clk) begin
        if (rst_n) begin : mdl
            bit st, done_rd;
            st = bus_we && !bus_addr && !busy_m;
            done_rd = 0;
            if (busy_m) begin
                k++;
                if (k == FR * PER) begin
                    busy_m = 0;
                    if (!dir_m) begin
                        data_m = {16'h0000, phy_val};
                        done_rd = 1;
                    end
                end
            end
            if (st) begin
                phy_m = bus_wdata[15:11];
                reg_m = bus_wdata[10:6];
                dir_m = bus_wdata[1];
                busy_m = 1;
                k = 0;
                frame_m = {32'hFFFF_FFFF, 2'b01, (dir_m ? 2'b01 : 2'b10), phy_m, reg_m,
                           (dir_m ? 2'b10 : 2'b00), (dir_m ? data_m[15:0] : 16'h0000)};
            end
            if (bus_we && bus_addr && !done_rd) data_m = bus_wdata;
        end
    end

    // compare every cycle, away from the edges; PHY drives read data
    always @(negedge clk) begin
        #2;
        if (running && !finished) begin : cmp
            int b;
            logic oe_e;
            b = busy_m ? k / PER : 0;
            chk("R4 mdc", {31'b0, mdc}, {31'b0, busy_m ? logic'((k / HALF) % 2) : 1'b0});
            oe_e = busy_m && (dir_m || b < 46);
            chk(dir_m ? "R6 oe" : "R7 oe", {31'b0, mdio_oe}, {31'b0, oe_e});
            if (oe_e)
                chk(b < 46 ? "R5 bit" : "R6 bit", {31'b0, mdio_o}, {31'b0, frame_m[63-b]});
            if (bus_addr)
                chk("R10 data readback", bus_rdata, data_m);
            else
                chk("R2 R8 R9 ctl readback", bus_rdata,
                    {16'h0000, phy_m, reg_m, 4'b0000, dir_m, busy_m});
            mdio_i <= (busy_m && !dir_m && b >= 48) ? phy_val[63-b] : 1'b1;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
            report();
        end
    end

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_m) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk("R1 mdc", {31'b0, mdc}, 32'h0);
        chk("R1 oe", {31'b0, mdio_oe}, 32'h0);
        chk("R1 ctl", bus_rdata, 32'h0);
        bus_addr = 1'b1;
        #1;
        chk("R1 data", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1;

        // R10: data register keeps all 32 bits
        bus_write(1'b1, 32'h1234_ABCD);
        #2 chk("R10 word", bus_rdata, 32'h1234_ABCD);

        // R3 R6: write frame starts the cycle after the command write
        bus_write(1'b1, 32'h0000_A5C3);
        bus_write(1'b0, ctl_word(5'd5, 5'h11, 1'b1));
        #2;
        chk("R3 busy", {31'b0, bus_rdata[0]}, 32'h1);
        chk("R3 oe", {31'b0, mdio_oe}, 32'h1);

        // R9: command write while busy has no effect
        repeat (40) @(negedge clk);
        bus_write(1'b0, ctl_word(5'd9, 5'd3, 1'b0));
        // data write mid-frame must not alter the frame on the wire (R6)
        bus_write(1'b1, 32'h0000_0F0F);
        bus_addr = 1'b0;
        wait_idle();
        #2 chk("R9 fields kept", bus_rdata, ctl_word(5'd5, 5'h11, 1'b1));

        // R7: read frames
        phy_val = 16'hBEEF;
        bus_write(1'b0, ctl_word(5'h1F, 5'h00, 1'b0));
        wait_idle();
        bus_addr = 1'b1;
        #2 chk("R7 read BEEF", bus_rdata, 32'h0000_BEEF);

        bus_write(1'b1, 32'hFFFF_FFFF);
        phy_val = 16'h0001;
        bus_write(1'b0, ctl_word(5'h00, 5'h1F, 1'b0));
        wait_idle();
        bus_addr = 1'b1;
        #2 chk("R7 read 0001", bus_rdata, 32'h0000_0001);

        // R6: all-zero payload, all-ones addresses
        bus_write(1'b1, 32'hFFFF_0000);
        bus_write(1'b0, ctl_word(5'h1F, 5'h1F, 1'b1));
        wait_idle();

        // R8: busy duration
        bus_write(1'b1, 32'h0000_8001);
        bus_write(1'b0, ctl_word(5'd1, 5'd2, 1'b1));
        bus_addr = 1'b0;
        begin
            int n;
            n = 0;
            #2;
            while (bus_rdata[0] === 1'b1 && n < 2000) begin
                @(negedge clk);
                #2;
                n++;
            end
            chk("R8 busy cycles", n, FR * PER);
        end
        wait_idle();

        finished = 1;
        report();
    end
endmodule